// File: doc/BRIEF.md
# CPU-cycle interrupt counter with scanline prescaler

This block raises a level interrupt after a programmable number of counting steps. It is clocked once per CPU cycle. An 8-bit counter is preset from a reload value and counts upward. When it is stepped while it holds the all-ones value, it takes the reload value again and raises the interrupt. A step comes either on every CPU cycle or about once per video scanline. In scanline mode a signed prescaler is used: each cycle removes a small step from a period value, and each time the prescaler falls to zero or below, the period is added back and the counter steps.

Software drives the block through three write-only registers, chosen by a 2-bit select input. The reload register holds the preset value. The control register holds the mode, the enable and a saved enable copy that the acknowledge register restores. The interrupt output stays high until software clears it with a control or acknowledge write.

Top module: `irq_tick_counter`

## Requirements
- R1: A write with select 0 stores wr_data[7:0] as the reload value; the counter is not changed by this write.
- R2: Each counting step increments the counter by one; a step taken while the counter holds 0xFF instead loads the reload value and drives irq_o high at that same edge.
- R3: With control bit 2 set (cycle mode) and enable set, every cycle with wr_en low is one counting step; the prescaler plays no part.
- R4: With control bit 2 clear (scanline mode) and enable set, every cycle with wr_en low subtracts 3 from the prescaler; when the result is zero or below, 341 is added to it and one counting step occurs, so a fresh start with reload 0xFF raises irq_o at the 114th such cycle.
- R5: A write with select 1 loads mode from bit 2, enable from bit 1 and the saved copy from bit 0, and clears irq_o; if bit 1 is set, the same write loads the counter from the reload value and the prescaler with 341.
- R6: A write with select 2 clears irq_o and copies the saved bit into enable, leaving the counter and prescaler unchanged.
- R7: While enable is clear, neither the counter nor the prescaler changes and irq_o never rises.
- R8: Reset clears the reload value, counter, prescaler, mode, enable, saved bit and irq_o.
- R9: A cycle with wr_en high performs no counting step, whatever the select; select 3 changes no state.
- R10: Once high, irq_o stays high until a select 1 or select 2 write; reload writes and further counting leave it high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe for this cycle |
| wr_sel | input | 2 | Register select: 0 reload, 1 control, 2 acknowledge, 3 none |
| wr_data | input | 8 | Write data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a period of 341 and a step of 3. Because 341 is not a multiple of 3, the prescaler passes through remainders of 0, -1 and -2 in turn, so the uneven scanline spacing is covered by a few hundred cycles. Reload values near 0xFF keep waits for the interrupt short. A reload of zero in cycle mode covers the full 256-step span.

// File: rtl/irq_cnt_pkg.sv
package irq_cnt_pkg;

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_ACK    = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int CTRL_MODE_BIT = 2;
    localparam int CTRL_EN_BIT   = 1;
    localparam int CTRL_KEEP_BIT = 0;

endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_cnt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  latch_o,
    output logic              mode_o,
    output logic              en_o,
    output logic              clr_irq_o,
    output logic              reload_o
);

    typedef struct packed {
        logic [CNT_W-1:0] latch;
        logic             mode;
        logic             en;
        logic             keep;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;
    reg_sel_e    sel;

    assign sel = reg_sel_e'(wr_sel);

    always_comb begin
        s_d       = s_q;
        clr_irq_o = 1'b0;
        reload_o  = 1'b0;
        if (wr_en) begin
            case (sel)
                SEL_RELOAD: s_d.latch = wr_data[CNT_W-1:0];
                SEL_CTRL: begin
                    s_d.mode  = wr_data[CTRL_MODE_BIT];
                    s_d.en    = wr_data[CTRL_EN_BIT];
                    s_d.keep  = wr_data[CTRL_KEEP_BIT];
                    clr_irq_o = 1'b1;
                    reload_o  = wr_data[CTRL_EN_BIT];
                end
                SEL_ACK: begin
                    s_d.en    = s_q.keep;
                    clr_irq_o = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign latch_o = s_q.latch;
    assign mode_o  = s_q.mode;
    assign en_o    = s_q.en;

    // R6
    ack_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_ACK) |=> (s_q.en == $past(s_q.keep)));

    // R9
    none_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=> $stable(s_q));

endmodule

// File: rtl/irq_prescaler.sv
module irq_prescaler #(
    parameter int PERIOD = 341,
    parameter int STEP   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic reload_i,
    output logic tick_o
);

    localparam int PRE_W = $clog2(PERIOD + 1) + 1;
    localparam logic signed [PRE_W-1:0] PER_V  = PRE_W'(PERIOD);
    localparam logic signed [PRE_W-1:0] STEP_V = PRE_W'(STEP);
    localparam logic signed [PRE_W-1:0] ZERO_V = '0;

    typedef struct packed {
        logic signed [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t              s_d, s_q;
    logic signed [PRE_W-1:0] dec;

    always_comb begin
        s_d    = s_q;
        dec    = s_q.pre - STEP_V;
        tick_o = run_i && (dec <= ZERO_V);
        if (reload_i) begin
            s_d.pre = PER_V;
        end else if (run_i) begin
            s_d.pre = tick_o ? (dec + PER_V) : dec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R4
    always @(posedge clk) begin
        if (rst_n) begin
            pre_range_chk: assert (s_q.pre <= PER_V && s_q.pre > -STEP_V);
        end
    end

    // R7
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !reload_i) |=> $stable(s_q.pre));

endmodule

// File: rtl/irq_count_core.sv
module irq_count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             reload_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] latch_i,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (reload_i) begin
            s_d.cnt = latch_i;
        end else if (step_i) begin
            if (s_q.cnt == CNT_MAX) begin
                s_d.cnt = latch_i;
                s_d.irq = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        if (clr_i) begin
            s_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_o = s_q.irq;

    // R2
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.irq) |-> ($past(s_q.cnt) == CNT_MAX && s_q.cnt == $past(latch_i)));

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.irq && !clr_i) |=> s_q.irq);

endmodule

// File: rtl/irq_tick_counter.sv
module irq_tick_counter
    import irq_cnt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter int PERIOD = 341,
    parameter int STEP   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq_o
);

    logic [CNT_W-1:0] latch_w;
    logic             mode_w;
    logic             en_w;
    logic             clr_w;
    logic             reload_w;
    logic             run_w;
    logic             tick_w;
    logic             step_w;

    irq_ctrl_regs #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .latch_o  (latch_w),
        .mode_o   (mode_w),
        .en_o     (en_w),
        .clr_irq_o(clr_w),
        .reload_o (reload_w)
    );

    assign run_w  = en_w && !wr_en && !mode_w;
    assign step_w = en_w && !wr_en && (mode_w || tick_w);

    irq_prescaler #(
        .PERIOD(PERIOD),
        .STEP  (STEP)
    ) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_w),
        .reload_i(reload_w),
        .tick_o  (tick_w)
    );

    irq_count_core #(
        .CNT_W(CNT_W)
    ) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step_w),
        .reload_i(reload_w),
        .clr_i   (clr_w),
        .latch_i (latch_w),
        .irq_o   (irq_o)
    );

    // R5
    ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel inside {2'd1, 2'd2}) |=> !irq_o);

    // R9
    rise_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(en_w && !wr_en));

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_w && !wr_en) |=> !$rose(irq_o));

endmodule

// File: tb/test_irq_tick_counter.sv
module test_irq_tick_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = 8'h00;
    logic       irq_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string phase = "R8";

    // reference model state
    int m_latch, m_cnt, m_pre, m_mode, m_en, m_keep, m_irq;

    always #4 clk = ~clk;

    irq_tick_counter i_irq_tick_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .irq_o  (irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s irq actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic model_step();
        if (!rst_n) begin
            m_latch = 0; m_cnt = 0; m_pre = 0; m_mode = 0;
            m_en = 0; m_keep = 0; m_irq = 0;
        end else if (wr_en) begin
            if (wr_sel == 2'd0) m_latch = wr_data;
            else if (wr_sel == 2'd1) begin
                m_mode = wr_data[2]; m_en = wr_data[1]; m_keep = wr_data[0];
                m_irq = 0;
                if (m_en != 0) begin m_cnt = m_latch; m_pre = 341; end
            end else if (wr_sel == 2'd2) begin
                m_en = m_keep; m_irq = 0;
            end
        end else if (m_en != 0) begin
            bit stp = 0;
            if (m_mode != 0) stp = 1;
            else begin
                m_pre -= 3;
                if (m_pre <= 0) begin m_pre += 341; stp = 1; end
            end
            if (stp) begin
                if (m_cnt == 255) begin m_cnt = m_latch; m_irq = 1; end
                else m_cnt++;
            end
        end
    endtask

    always @(posedge clk) begin
        model_step();
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) check(phase, int'(irq_o), m_irq);
    end

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // counts edges after the write edge until irq_o is seen high
    task automatic wait_irq(output int n);
        n = 0;
        while (!irq_o && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    int n;

    initial begin
        idle(3);
        check("R8", int'(irq_o), 0);
        rst_n = 1'b1;
        idle(2);
        check("R8", int'(irq_o), 0);

        // R8: latch is zero after reset, cycle mode takes 256 steps
        phase = "R8";
        wr(2'd1, 8'h06);
        wait_irq(n);
        check("R8", n, 256);

        // R3: cycle mode with reload 0xFB
        phase = "R3";
        wr(2'd0, 8'hFB);
        wr(2'd1, 8'h06);
        wait_irq(n);
        check("R3", n, 5);

        // R10: reload write and more steps keep irq high
        phase = "R10";
        wr(2'd0, 8'h10);
        idle(20);
        check("R10", int'(irq_o), 1);

        // R4: scanline mode, reload 0xFF -> 114 cycles
        phase = "R4";
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h02);
        wait_irq(n);
        check("R4", n, 114);
        idle(700);

        // R6: ack with saved bit set keeps counting
        phase = "R6";
        wr(2'd0, 8'hF0);
        wr(2'd1, 8'h07);
        wait_irq(n);
        check("R2", n, 16);
        wr(2'd2, 8'h00);
        check("R6", int'(irq_o), 0);
        wait_irq(n);
        check("R6", n, 15);
        // ack with saved bit clear stops counting
        wr(2'd1, 8'h06);
        wr(2'd2, 8'h00);
        phase = "R7";
        idle(400);
        check("R7", int'(irq_o), 0);

        // R9: write cycles with select 3 stall counting
        phase = "R9";
        wr(2'd0, 8'hFC);
        wr(2'd1, 8'h06);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'hFF;
        idle(10);
        wr_en = 1'b0;
        check("R9", int'(irq_o), 0);
        wait_irq(n);
        check("R9", n, 3);

        // R5: control write without enable clears irq and freezes state
        phase = "R5";
        wr(2'd1, 8'h04);
        check("R5", int'(irq_o), 0);
        idle(50);

        // R1: mixed traffic compared against the model each cycle
        phase = "R1";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 15) == 0) begin
                wr_en = 1'b1;
                wr_sel = 2'($urandom_range(0, 3));
                wr_data = 8'($urandom_range(0, 255));
                if (wr_sel == 2'd0) wr_data = 8'hF8 | wr_data[2:0];
                if (wr_sel == 2'd1) wr_data[1] = 1'b1;
            end else begin
                wr_en = 1'b0;
                wr_sel = 2'd3;
            end
        end
        wr_en = 1'b0;
        idle(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule